// File: doc/BRIEF.md
# Descriptor Ring Slot Sequencer

This block walks a descriptor ring that lives in system memory on behalf of an infrared link controller. The ring has two sub-rings that share one base address aligned to 1 KB: receive slots start at the base and transmit slots start 0x200 bytes (64 slots) further on. Each slot is 8 bytes. Word 0 holds a 16-bit length in bits 15..0, of which the low 12 bits are valid, a spare byte in bits 23..16, and the control/status byte in bits 31..24. Word 1 holds the 32-bit buffer address. The block keeps one 6-bit slot pointer per sub-ring. For every slot whose ownership bit (bit 7 of the control byte) is set, it hands the length, buffer address and control byte to an external data mover. It then writes back the control/status byte with the ownership bit cleared, and moves to the next slot.

Software configures the block through an 8-bit register write port: three bytes of ring base, one ring-size byte and a prompt register. A prompt starts a scan of the receive sub-ring and then of the transmit sub-ring. Each scan runs until it meets a slot that hardware does not own. Single-cycle event pulses report completed receive slots, transmit slots that asked for a done event, transmit underruns and receive overflows.

The sequencer has five states. `S_IDLE` waits for a pending scan. It takes the receive sub-ring first and goes to `S_RD_DESC`. `S_RD_DESC` reads word 0. It goes to `S_RD_BUF` when the slot is owned and back to `S_IDLE` when it is not. `S_RD_BUF` reads word 1 and goes to `S_MOVE`. `S_MOVE` holds the mover request until the mover reports done, then goes to `S_WRITE_BACK`. `S_WRITE_BACK` writes the control byte, advances the pointer, raises the events and returns to `S_RD_DESC` on the same sub-ring.

Top module: `ir_ring_sequencer`

## Requirements
- R1: Register 0 holds base address bits 17..10, register 1 holds bits 25..18, and bits 5..0 of register 2 hold bits 31..26; base bits 9..0 are zero. Receive slot n is at base + 8n and transmit slot n is at base + 0x200 + 8n.
- R2: Each descriptor is fetched as a read of word 0 at the slot address, then a read of word 1 at slot address + 4. The mover receives length bits 11..0 of word 0, word 1 as the buffer address, and word-0 bits 31..24 as the control byte.
- R3: A slot is processed only when word-0 bit 31 is set. A read that finds the bit clear ends the scan of that sub-ring, leaves its pointer on that slot and writes nothing.
- R4: The write-back is a single write to word 0 with byte enables 4'b1000, so only bits 31..24 change. For transmit, the byte is {0, control bits 6..1, mover status bit 0}. For receive, it is {0, mover status bits 6..1, 0}.
- R5: Register 3 sets the sub-ring sizes: bits 3..0 for receive and bits 7..4 for transmit, with code 0x0=4, 0x1=8, 0x3=16, 0x7=32 and 0xF=64 slots. After the last slot the pointer wraps to 0.
- R6: A write of register 4 with bit 0 set requests a scan of both sub-rings; a write with bit 0 clear has no effect. The receive scan runs before the transmit scan.
- R7: A prompt that arrives while a scan runs, even in the cycle its pending request is consumed, is kept, so the sub-ring is scanned again afterwards.
- R8: In the cycle after the write-back is accepted, and for one cycle only: `ev_rx_done` pulses for every receive slot, and `ev_rx_over` pulses when receive status bit 3 is set; `ev_tx_done` pulses for a transmit slot whose control bit 2 is set, and `ev_tx_under` pulses when transmit status bit 0 is set. The slot pointer advances in that same cycle.
- R9: After reset both slot pointers are 0, no memory or mover request is raised, and all events are low.
- R10: `mem_req` and `xfer_req` each stay high, with stable address and fields, until `mem_ack` or `xfer_done` respectively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select (0..4) |
| reg_wdata | input | 8 | Register write data |
| rx_slot | output | 6 | Current receive slot pointer |
| tx_slot | output | 6 | Current transmit slot pointer |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_be | output | 4 | Byte enables |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Response strobe for the current request |
| mem_rdata | input | 32 | Read data valid with `mem_ack` |
| xfer_req | output | 1 | Data-mover request, held until done |
| xfer_tx | output | 1 | 1 = transmit slot, 0 = receive slot |
| xfer_len | output | 12 | Slot length |
| xfer_addr | output | 32 | Slot buffer address |
| xfer_ctl | output | 8 | Slot control byte as fetched |
| xfer_done | input | 1 | Mover completion strobe |
| xfer_status | input | 8 | Mover status, valid with `xfer_done` |
| ev_tx_done | output | 1 | Transmit slot done pulse (when requested) |
| ev_rx_done | output | 1 | Receive slot done pulse |
| ev_tx_under | output | 1 | Transmit underrun pulse |
| ev_rx_over | output | 1 | Receive overflow pulse |

## Verification
Two things can fall in the same clock edge here: a new prompt write, and the sequencer consuming the pending scan request it set earlier. The bench provokes this with two prompt writes in consecutive cycles while every slot is free. The second write lands on the edge where `S_IDLE` takes the first request. The result is judged at the memory port by counting reads of the current receive descriptor, which must be two, not one. A second case issues a prompt while a slot transfer is in flight and expects the next free slot's descriptor to be read again after the transmit scan.

// File: rtl/ir_ring_pkg.sv
package ir_ring_pkg;

    localparam int AW    = 32;
    localparam int DW    = 32;
    localparam int PTR_W = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_DESC,
        S_RD_BUF,
        S_MOVE,
        S_WRITE_BACK
    } seq_state_t;

    // Size code (4 bits) to pointer wrap mask: codes 0,1,3,7,F give 3,7,15,31,63.
    function automatic logic [PTR_W-1:0] size_code_mask(input logic [3:0] code);
        return {code, 2'b11};
    endfunction

endpackage

// File: rtl/ring_cfg_regs.sv
module ring_cfg_regs
    import ir_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    input  logic             take_rx,
    input  logic             take_tx,
    output logic [AW-1:0]    ring_base,
    output logic [PTR_W-1:0] rx_mask,
    output logic [PTR_W-1:0] tx_mask,
    output logic             rx_pend,
    output logic             tx_pend
);

    localparam int ALIGN_W = 10;

    logic [7:0] base_a;
    logic [7:0] base_b;
    logic [5:0] base_c;
    logic [7:0] size_code;
    logic       prompt;

    assign prompt    = reg_wr && (reg_addr == 3'd4) && reg_wdata[0];
    assign ring_base = {base_c, base_b, base_a, {ALIGN_W{1'b0}}};
    assign rx_mask   = size_code_mask(size_code[3:0]);
    assign tx_mask   = size_code_mask(size_code[7:4]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_a    <= '0;
            base_b    <= '0;
            base_c    <= '0;
            size_code <= '0;
        end else if (reg_wr) begin
            unique case (reg_addr)
                3'd0:    base_a    <= reg_wdata;
                3'd1:    base_b    <= reg_wdata;
                3'd2:    base_c    <= reg_wdata[5:0];
                3'd3:    size_code <= reg_wdata;
                default: ;
            endcase
        end
    end

    // A new prompt wins over the consumption of an older one.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_pend <= 1'b0;
            tx_pend <= 1'b0;
        end else begin
            rx_pend <= (rx_pend && !take_rx) || prompt;
            tx_pend <= (tx_pend && !take_tx) || prompt;
        end
    end

    p_prompt_arms_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prompt |=> (rx_pend && tx_pend));

    p_prompt_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prompt && take_rx) |=> rx_pend);

endmodule

// File: rtl/ring_slot_ptr.sv
module ring_slot_ptr
    import ir_ring_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic [PTR_W-1:0] mask,
    output logic [PTR_W-1:0] ptr
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (step)
            ptr <= (ptr + 1'b1) & mask;
    end

    p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (ptr == mask)) |=> (ptr == '0));

endmodule

// File: rtl/ring_seq_fsm.sv
module ring_seq_fsm
    import ir_ring_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int TX_SLOT_OFS = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ring_base,
    input  logic [PTR_W-1:0] rx_ptr,
    input  logic [PTR_W-1:0] tx_ptr,
    input  logic             rx_pend,
    input  logic             tx_pend,
    output logic             take_rx,
    output logic             take_tx,
    output logic             step_rx,
    output logic             step_tx,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [3:0]       mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [DW-1:0]    mem_rdata,
    output logic             xfer_req,
    output logic             xfer_tx,
    output logic [LEN_W-1:0] xfer_len,
    output logic [AW-1:0]    xfer_addr,
    output logic [7:0]       xfer_ctl,
    input  logic             xfer_done,
    input  logic [7:0]       xfer_status,
    output logic             ev_tx_done,
    output logic             ev_rx_done,
    output logic             ev_tx_under,
    output logic             ev_rx_over
);

    localparam logic [AW-1:0] TX_BYTES  = AW'(TX_SLOT_OFS * 8);
    localparam int            OWN_BIT   = 31;
    localparam int            CTL_LSB   = 24;

    seq_state_t       state, state_n;
    logic             dir_tx;
    logic [LEN_W-1:0] desc_len;
    logic [7:0]       desc_ctl;
    logic [AW-1:0]    buf_addr;
    logic [7:0]       wb_byte;
    logic [AW-1:0]    slot_addr;
    logic             wb_accept;
    logic             unused_bits;

    assign unused_bits = ^{mem_rdata[CTL_LSB-1:LEN_W], xfer_status[7]};
    assign slot_addr   = ring_base + (dir_tx ? TX_BYTES : '0)
                       + AW'({dir_tx ? tx_ptr : rx_ptr, 3'b000});
    assign wb_accept   = (state == S_WRITE_BACK) && mem_ack;

    // Next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            S_IDLE:       if (rx_pend || tx_pend) state_n = S_RD_DESC;
            S_RD_DESC:    if (mem_ack) state_n = mem_rdata[OWN_BIT] ? S_RD_BUF : S_IDLE;
            S_RD_BUF:     if (mem_ack) state_n = S_MOVE;
            S_MOVE:       if (xfer_done) state_n = S_WRITE_BACK;
            S_WRITE_BACK: if (mem_ack) state_n = S_RD_DESC;
            default:      state_n = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        take_rx   = (state == S_IDLE) && rx_pend;
        take_tx   = (state == S_IDLE) && !rx_pend && tx_pend;
        step_rx   = wb_accept && !dir_tx;
        step_tx   = wb_accept && dir_tx;
        mem_req   = (state == S_RD_DESC) || (state == S_RD_BUF) || (state == S_WRITE_BACK);
        mem_we    = (state == S_WRITE_BACK);
        mem_be    = mem_we ? 4'b1000 : 4'b1111;
        mem_addr  = slot_addr + ((state == S_RD_BUF) ? AW'(4) : '0);
        mem_wdata = mem_we ? {wb_byte, 24'h0} : '0;
        xfer_req  = (state == S_MOVE);
        xfer_tx   = dir_tx;
        xfer_len  = desc_len;
        xfer_addr = buf_addr;
        xfer_ctl  = desc_ctl;
    end

    // State register and datapath capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state       <= S_IDLE;
            dir_tx      <= 1'b0;
            desc_len    <= '0;
            desc_ctl    <= '0;
            buf_addr    <= '0;
            wb_byte     <= '0;
            ev_tx_done  <= 1'b0;
            ev_rx_done  <= 1'b0;
            ev_tx_under <= 1'b0;
            ev_rx_over  <= 1'b0;
        end else begin
            state       <= state_n;
            ev_tx_done  <= 1'b0;
            ev_rx_done  <= 1'b0;
            ev_tx_under <= 1'b0;
            ev_rx_over  <= 1'b0;
            if (take_rx) dir_tx <= 1'b0;
            if (take_tx) dir_tx <= 1'b1;
            if (state == S_RD_DESC && mem_ack) begin
                desc_len <= mem_rdata[LEN_W-1:0];
                desc_ctl <= mem_rdata[DW-1:CTL_LSB];
            end
            if (state == S_RD_BUF && mem_ack)
                buf_addr <= mem_rdata;
            if (xfer_req && xfer_done)
                wb_byte <= dir_tx ? {1'b0, desc_ctl[6:1], xfer_status[0]}
                                  : {1'b0, xfer_status[6:1], 1'b0};
            if (wb_accept) begin
                ev_tx_done  <= dir_tx && desc_ctl[2];
                ev_tx_under <= dir_tx && wb_byte[0];
                ev_rx_done  <= !dir_tx;
                ev_rx_over  <= !dir_tx && wb_byte[3];
            end
        end
    end

    p_mem_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    p_xfer_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len)));

    p_wb_byte_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_be == 4'b1000 && !mem_wdata[OWN_BIT]));

    p_rx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rx_done |=> !ev_rx_done);

    p_tx_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ev_tx_done |=> !ev_tx_done);

    p_one_master_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req && xfer_req));

endmodule

// File: rtl/ir_ring_sequencer.sv
module ir_ring_sequencer
    import ir_ring_pkg::*;
#(
    parameter int LEN_W       = 12,
    parameter int TX_SLOT_OFS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [2:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [PTR_W-1:0]  rx_slot,
    output logic [PTR_W-1:0]  tx_slot,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [3:0]        mem_be,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic              xfer_req,
    output logic              xfer_tx,
    output logic [LEN_W-1:0]  xfer_len,
    output logic [AW-1:0]     xfer_addr,
    output logic [7:0]        xfer_ctl,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_status,
    output logic              ev_tx_done,
    output logic              ev_rx_done,
    output logic              ev_tx_under,
    output logic              ev_rx_over
);

    localparam int N_RING = 2;

    logic [AW-1:0]    ring_base;
    logic [PTR_W-1:0] mask [N_RING];
    logic [PTR_W-1:0] ptr  [N_RING];
    logic [N_RING-1:0] step;
    logic             rx_pend, tx_pend, take_rx, take_tx;

    ring_cfg_regs u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .take_rx   (take_rx),
        .take_tx   (take_tx),
        .ring_base (ring_base),
        .rx_mask   (mask[0]),
        .tx_mask   (mask[1]),
        .rx_pend   (rx_pend),
        .tx_pend   (tx_pend)
    );

    for (genvar d = 0; d < N_RING; d++) begin : g_ptr
        ring_slot_ptr u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .step  (step[d]),
            .mask  (mask[d]),
            .ptr   (ptr[d])
        );
    end

    assign rx_slot = ptr[0];
    assign tx_slot = ptr[1];

    ring_seq_fsm #(
        .LEN_W       (LEN_W),
        .TX_SLOT_OFS (TX_SLOT_OFS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ring_base   (ring_base),
        .rx_ptr      (ptr[0]),
        .tx_ptr      (ptr[1]),
        .rx_pend     (rx_pend),
        .tx_pend     (tx_pend),
        .take_rx     (take_rx),
        .take_tx     (take_tx),
        .step_rx     (step[0]),
        .step_tx     (step[1]),
        .mem_req     (mem_req),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_be      (mem_be),
        .mem_wdata   (mem_wdata),
        .mem_ack     (mem_ack),
        .mem_rdata   (mem_rdata),
        .xfer_req    (xfer_req),
        .xfer_tx     (xfer_tx),
        .xfer_len    (xfer_len),
        .xfer_addr   (xfer_addr),
        .xfer_ctl    (xfer_ctl),
        .xfer_done   (xfer_done),
        .xfer_status (xfer_status),
        .ev_tx_done  (ev_tx_done),
        .ev_rx_done  (ev_rx_done),
        .ev_tx_under (ev_tx_under),
        .ev_rx_over  (ev_rx_over)
    );

endmodule

// File: tb/ir_ring_sequencer_tb.sv
module ir_ring_sequencer_tb;

    typedef struct {
        logic        tx;
        logic [11:0] len;
        logic [31:0] addr;
        logic [7:0]  ctl;
        logic [7:0]  st;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [5:0]  rx_slot, tx_slot;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        xfer_req, xfer_tx;
    logic [11:0] xfer_len;
    logic [31:0] xfer_addr;
    logic [7:0]  xfer_ctl;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_status = '0;
    logic        ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] mem [0:255];
    logic [31:0] cur_base = '0;
    logic [31:0] watch_addr = 32'hFFFF_FFFF;
    int          watch_cnt = 0;
    int          xfer_seen = 0;
    int          mv_wait = 0;
    int          n_txd = 0, n_rxd = 0, n_txu = 0, n_rxo = 0;
    item_t       exp_q[$];

    always #5 clk = ~clk;

    ir_ring_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .rx_slot(rx_slot), .tx_slot(tx_slot),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .xfer_req(xfer_req), .xfer_tx(xfer_tx), .xfer_len(xfer_len), .xfer_addr(xfer_addr),
        .xfer_ctl(xfer_ctl), .xfer_done(xfer_done), .xfer_status(xfer_status),
        .ev_tx_done(ev_tx_done), .ev_rx_done(ev_rx_done),
        .ev_tx_under(ev_tx_under), .ev_rx_over(ev_rx_over)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int word_idx(input bit tx, input int slot);
        return (tx ? 128 : 0) + 2 * slot;
    endfunction

    task automatic load_slot(input bit tx, input int slot, input logic [15:0] len,
                             input logic [31:0] addr, input logic [7:0] ctl);
        mem[word_idx(tx, slot)]     = {ctl, 8'h5A, len};
        mem[word_idx(tx, slot) + 1] = addr;
    endtask

    task automatic expect_item(input bit tx, input logic [11:0] len, input logic [31:0] addr,
                               input logic [7:0] ctl, input logic [7:0] st);
        item_t it;
        it.tx = tx; it.len = len; it.addr = addr; it.ctl = ctl; it.st = st;
        exp_q.push_back(it);
    endtask

    // Driver: loads a slot and pushes the transfer the sequencer must request.
    task automatic put_slot(input bit tx, input int slot, input logic [15:0] len,
                            input logic [31:0] addr, input logic [7:0] ctl, input logic [7:0] st);
        load_slot(tx, slot, len, addr, ctl);
        expect_item(tx, len[11:0], addr, ctl, st);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_quiet();
        int idle = 0;
        while (idle < 30) begin
            @(negedge clk);
            if (mem_req || xfer_req) idle = 0; else idle++;
        end
    endtask

    task automatic clear_events();
        n_txd = 0; n_rxd = 0; n_txu = 0; n_rxo = 0;
    endtask

    // Memory responder: one-cycle latency, byte-enabled writes, address check (R1).
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req) begin
                chk("R1 base bits of request", {10'b0, mem_addr[31:10]}, {10'b0, cur_base[31:10]});
                if (!mem_we && mem_addr == watch_addr) watch_cnt++;
                if (mem_we) begin
                    for (int b = 0; b < 4; b++)
                        if (mem_be[b]) mem[mem_addr[9:2]][8*b +: 8] = mem_wdata[8*b +: 8];
                end else begin
                    mem_rdata = mem[mem_addr[9:2]];
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Monitor: pops the scoreboard on each mover request and compares (R2, R10).
    initial begin
        forever begin
            @(negedge clk);
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_req) begin
                mv_wait++;
                if (mv_wait >= 2) begin
                    mv_wait = 0;
                    xfer_seen++;
                    if (exp_q.size() == 0) begin
                        chk("R3 unexpected transfer", {31'b0, xfer_req}, 32'h0);
                        xfer_status = 8'h00;
                    end else begin
                        item_t it;
                        it = exp_q.pop_front();
                        chk("R6 direction order", {31'b0, xfer_tx}, {31'b0, it.tx});
                        chk("R2 length", {20'b0, xfer_len}, {20'b0, it.len});
                        chk("R2 buffer address", xfer_addr, it.addr);
                        chk("R10 control byte", {24'b0, xfer_ctl}, {24'b0, it.ctl});
                        xfer_status = it.st;
                    end
                    xfer_done = 1'b1;
                end
            end
        end
    end

    // Event counters
    initial begin
        forever begin
            @(negedge clk);
            if (ev_tx_done)  n_txd++;
            if (ev_rx_done)  n_rxd++;
            if (ev_tx_under) n_txu++;
            if (ev_rx_over)  n_rxo++;
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R9: reset state
        chk("R9 rx_slot reset", {26'b0, rx_slot}, 32'h0);
        chk("R9 tx_slot reset", {26'b0, tx_slot}, 32'h0);
        chk("R9 mem_req reset", {31'b0, mem_req}, 32'h0);
        chk("R9 xfer_req reset", {31'b0, xfer_req}, 32'h0);
        chk("R9 events reset", {28'b0, ev_tx_done, ev_rx_done, ev_tx_under, ev_rx_over}, 32'h0);
        rst_n = 1'b1;

        // Test A: base, fetch, write-back, events (R1 R2 R3 R4 R6 R8)
        cur_base = 32'h1234_5400;
        reg_write(3'd0, cur_base[17:10]);
        reg_write(3'd1, cur_base[25:18]);
        reg_write(3'd2, {2'b11, cur_base[31:26]});
        reg_write(3'd3, 8'h00);
        put_slot(1'b0, 0, 16'hF123, 32'h8000_1000, 8'h80, 8'h42);
        put_slot(1'b0, 1, 16'h0040, 32'h8000_2000, 8'h80, 8'h0A);
        load_slot(1'b0, 2, 16'h0011, 32'h0, 8'h00);
        put_slot(1'b1, 0, 16'h07FF, 32'h9000_0000, 8'hC4, 8'h01);
        load_slot(1'b1, 1, 16'h0022, 32'h0, 8'h00);
        clear_events();
        reg_write(3'd4, 8'h01);
        wait_quiet();
        chk("R2 all transfers seen", exp_q.size(), 0);
        chk("R4 rx0 write-back word", mem[word_idx(0, 0)], 32'h425A_F123);
        chk("R4 rx1 write-back word", mem[word_idx(0, 1)], 32'h0A5A_0040);
        chk("R4 tx0 write-back word", mem[word_idx(1, 0)], 32'h455A_07FF);
        chk("R3 unowned rx2 untouched", mem[word_idx(0, 2)], 32'h005A_0011);
        chk("R3 rx pointer stops at free slot", {26'b0, rx_slot}, 32'd2);
        chk("R3 tx pointer stops at free slot", {26'b0, tx_slot}, 32'd1);
        chk("R8 rx_done count", n_rxd, 2);
        chk("R8 rx_over count", n_rxo, 1);
        chk("R8 tx_done count", n_txd, 1);
        chk("R8 tx_under count", n_txu, 1);

        // Test B: wrap at 4 slots (R5)
        put_slot(1'b0, 2, 16'h0100, 32'hA000_0002, 8'h80, 8'h02);
        put_slot(1'b0, 3, 16'h0101, 32'hA000_0003, 8'h80, 8'h02);
        put_slot(1'b0, 0, 16'h0102, 32'hA000_0000, 8'h80, 8'h02);
        clear_events();
        reg_write(3'd4, 8'h01);
        wait_quiet();
        chk("R5 wrap after four slots", {26'b0, rx_slot}, 32'd1);
        chk("R5 wrap transfers seen", exp_q.size(), 0);
        chk("R8 rx_done count after wrap", n_rxd, 3);

        // Test C: size code 0x31 -> 8 rx slots (R5)
        reg_write(3'd3, 8'h31);
        for (int s = 1; s < 8; s++)
            put_slot(1'b0, s, 16'(s), 32'hB000_0000 + 32'(s), 8'h80, 8'h02);
        reg_write(3'd4, 8'h01);
        wait_quiet();
        chk("R5 wrap after eight slots", {26'b0, rx_slot}, 32'd0);
        chk("R5 eight-slot transfers seen", exp_q.size(), 0);

        // Test D: prompt with bit 0 clear is ignored (R6)
        load_slot(1'b0, 0, 16'h0055, 32'hC000_0000, 8'h80);
        xfer_seen = 0;
        reg_write(3'd4, 8'h02);
        repeat (40) @(negedge clk);
        chk("R6 no transfer without prompt bit", xfer_seen, 0);
        chk("R6 rx pointer unchanged", {26'b0, rx_slot}, 32'd0);
        expect_item(1'b0, 12'h055, 32'hC000_0000, 8'h80, 8'h02);
        reg_write(3'd4, 8'h01);
        wait_quiet();
        chk("R6 prompt bit starts scan", {26'b0, rx_slot}, 32'd1);

        // Test E: prompt in the cycle the pending request is consumed (R7)
        watch_addr = cur_base + 32'd8;
        watch_cnt = 0;
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h01;
        @(negedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        wait_quiet();
        chk("R7 back-to-back prompt rescans rx", watch_cnt, 2);

        // Test F: prompt during a live transfer (R7)
        put_slot(1'b0, 1, 16'h0066, 32'hD000_0000, 8'h84, 8'h02);
        watch_addr = cur_base + 32'd16;
        watch_cnt = 0;
        reg_write(3'd4, 8'h01);
        while (!xfer_req) @(negedge clk);
        reg_write(3'd4, 8'h01);
        wait_quiet();
        chk("R7 prompt during transfer kept", watch_cnt, 2);
        chk("R7 rx pointer after rescan", {26'b0, rx_slot}, 32'd2);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule